// File: doc/BRIEF.md
# Retained Boot-Image Copy Engine

This block keeps a small boot image in a 1024-byte memory that stays powered. The host fills that memory with 32-bit words over a simple register bus. On request, the block copies a run of dwords from it into a target instruction memory through a word write port. The copy uses a source offset, a destination word address and a dword count that the host programs beforehand.

A copy can start in two ways. The host can write the start bit (bit 31) of the control register, and that bit then reads back 1 until the copy has finished. The host can also set the arm bit (bit 30), and the same copy then runs again on every power-up event pulse without any further host action.

Completion shows in two places: bit 31 of the control register falls to 0, and bit 0 of the status register becomes 1. The engine moves one dword per clock. Reads from the retained memory take one cycle.

Top module: `boot_copy_engine`

## Requirements
- R1: After reset, the control register (offset 0x00), source (0x04), destination (0x08), count (0x0C) and status (0x10) all read 0, and the target write strobe is low.
- R2: A bus write to byte address 0x400 + 4*i stores the data in word i of the retained memory. That word is what a later copy delivers.
- R3: Writing control with bit 31 set starts a copy of `count` dwords. Source word index is source[9:2]. Destination word addresses go up from the destination register. One write happens per clock, and the first write appears one cycle after the start edge.
- R4: Control bit 31 reads 1 from the start edge until the final target write has been presented. It reads 0 from the cycle after that.
- R5: Status bit 0 reads 1 once a copy has completed. It is cleared on the edge where a new copy with a nonzero count starts.
- R6: While control bit 30 is 1, a power-up event pulse starts a copy with the programmed source, destination and count. While bit 30 is 0, the pulse has no effect.
- R7: A start with count 0 performs no target writes. It sets status bit 0 at once, and control bit 31 reads 0.
- R8: Writes to source, destination or count while a copy is running are ignored, and the running copy keeps its settings.
- R9: A start request (bit 31 write or power-up pulse) made while a copy is running has no effect.
- R10: The source word index wraps modulo 256, and the destination address wraps modulo the target memory size.
- R11: The target write strobe is high only while a copy is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 11 | Byte address: registers below 0x400, retained memory window at 0x400-0x7FF |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle (memory window reads 0) |
| pwr_up_evt | input | 1 | Single-cycle power-up event pulse |
| imem_we | output | 1 | Target instruction memory write strobe |
| imem_addr | output | 12 | Target word address |
| imem_wdata | output | 32 | Target write data |

## Verification
The properties assume that a power-up pulse lasts one cycle and that reset is applied before any bus traffic. The stimulus drives every bus access and event pulse as a single-cycle strobe, away from the clock edge. The properties also assume that the host does not rewrite a retained memory word while a copy is reading it. The stimulus fills the memory only while the engine is idle, and it pushes reconfiguration writes and repeated start requests into the busy window on purpose to test the hold and ignore rules.

// File: rtl/bce_pkg.sv
package bce_pkg;

  localparam int unsigned CTRL_GO_BIT  = 31;
  localparam int unsigned CTRL_ARM_BIT = 30;

  localparam logic [4:0] OFF_CTRL = 5'h00;
  localparam logic [4:0] OFF_SRC  = 5'h04;
  localparam logic [4:0] OFF_DST  = 5'h08;
  localparam logic [4:0] OFF_CNT  = 5'h0C;
  localparam logic [4:0] OFF_STAT = 5'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_SRC,
    SEL_DST,
    SEL_CNT,
    SEL_STAT,
    SEL_RAM
  } bus_sel_e;

  function automatic bus_sel_e decode_sel(input logic in_ram,
                                          input logic hi_zero,
                                          input logic [4:0] off);
    bus_sel_e s;
    s = SEL_NONE;
    if (in_ram) s = SEL_RAM;
    else if (hi_zero) begin
      case (off)
        OFF_CTRL: s = SEL_CTRL;
        OFF_SRC:  s = SEL_SRC;
        OFF_DST:  s = SEL_DST;
        OFF_CNT:  s = SEL_CNT;
        OFF_STAT: s = SEL_STAT;
        default:  s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/bce_retained_ram.sv
module bce_retained_ram #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/bce_regs.sv
module bce_regs
  import bce_pkg::*;
#(
  parameter int RAM_WORDS = 256,
  parameter int IMEM_AW   = 12,
  localparam int RAM_AW   = $clog2(RAM_WORDS),
  localparam int BYTE_AW  = RAM_AW + 2,
  localparam int BUS_AW   = BYTE_AW + 1,
  localparam int CNT_W    = RAM_AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               pwr_up_evt,
  input  logic               busy,
  input  logic               finish,
  output logic               launch,
  output logic [RAM_AW-1:0]  src_w,
  output logic [IMEM_AW-1:0] dst,
  output logic [CNT_W-1:0]   cnt,
  output logic               arm,
  output logic               done,
  output logic               ram_we,
  output logic [RAM_AW-1:0]  ram_waddr,
  output logic [31:0]        ram_wdata
);

  bus_sel_e sel;
  logic     go_req;
  logic     start;
  logic     cfg_open;

  assign sel = decode_sel(bus_addr[BYTE_AW], bus_addr[BYTE_AW-1:5] == '0,
                          bus_addr[4:0]);

  assign ram_we    = bus_we && (sel == SEL_RAM);
  assign ram_waddr = bus_addr[BYTE_AW-1:2];
  assign ram_wdata = bus_wdata;

  // host kick or armed power-up event; both ignored while a copy runs
  assign go_req = (bus_we && (sel == SEL_CTRL) && bus_wdata[CTRL_GO_BIT]) ||
                  (pwr_up_evt && arm);
  assign start    = go_req && !busy;
  assign launch   = start && (cnt != '0);
  assign cfg_open = bus_we && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_w <= '0;
      dst   <= '0;
      cnt   <= '0;
      arm   <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (cfg_open && sel == SEL_SRC) src_w <= bus_wdata[BYTE_AW-1:2];
      if (cfg_open && sel == SEL_DST) dst   <= bus_wdata[IMEM_AW-1:0];
      if (cfg_open && sel == SEL_CNT) cnt   <= bus_wdata[CNT_W-1:0];
      if (bus_we && sel == SEL_CTRL)  arm   <= bus_wdata[CTRL_ARM_BIT];
      if (start)       done <= (cnt == '0);
      else if (finish) done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (sel)
        SEL_CTRL: bus_rdata <= {busy, arm, 30'b0};
        SEL_SRC:  bus_rdata <= {{(32-BYTE_AW){1'b0}}, src_w, 2'b00};
        SEL_DST:  bus_rdata <= {{(32-IMEM_AW){1'b0}}, dst};
        SEL_CNT:  bus_rdata <= {{(32-CNT_W){1'b0}}, cnt};
        SEL_STAT: bus_rdata <= {31'b0, done};
        default:  bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/bce_mover.sv
module bce_mover #(
  parameter int RAM_AW  = 8,
  parameter int IMEM_AW = 12,
  localparam int CNT_W  = RAM_AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic [RAM_AW-1:0]  src_w,
  input  logic [IMEM_AW-1:0] dst,
  input  logic [CNT_W-1:0]   cnt,
  output logic               busy,
  output logic               finish,
  output logic               ram_re,
  output logic [RAM_AW-1:0]  ram_raddr,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr
);

  logic [CNT_W-1:0]   left;
  logic [RAM_AW-1:0]  rd_ptr;
  logic [IMEM_AW-1:0] wr_ptr;

  // a read is issued while words remain; its write follows one cycle later
  assign ram_re    = busy && (left != '0);
  assign ram_raddr = rd_ptr;
  assign finish    = busy && (left == '0) && imem_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      left      <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      imem_we   <= 1'b0;
      imem_addr <= '0;
    end else begin
      imem_we <= ram_re;
      if (ram_re) begin
        rd_ptr    <= rd_ptr + 1'b1;
        left      <= left - 1'b1;
        imem_addr <= wr_ptr;
        wr_ptr    <= wr_ptr + 1'b1;
      end
      if (launch) begin
        busy   <= 1'b1;
        left   <= cnt;
        rd_ptr <= src_w;
        wr_ptr <= dst;
      end else if (finish) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
  parameter int RAM_WORDS = 256,
  parameter int IMEM_AW   = 12,
  localparam int RAM_AW   = $clog2(RAM_WORDS),
  localparam int BUS_AW   = RAM_AW + 3,
  localparam int CNT_W    = RAM_AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               pwr_up_evt,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [31:0]        imem_wdata
);

  logic               busy;
  logic               finish;
  logic               launch;
  logic               arm;
  logic               done;
  logic [RAM_AW-1:0]  src_w;
  logic [IMEM_AW-1:0] dst;
  logic [CNT_W-1:0]   cnt;
  logic               ram_we;
  logic [RAM_AW-1:0]  ram_waddr;
  logic [31:0]        ram_wdata;
  logic               ram_re;
  logic [RAM_AW-1:0]  ram_raddr;

  bce_regs #(.RAM_WORDS(RAM_WORDS), .IMEM_AW(IMEM_AW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwr_up_evt(pwr_up_evt),
    .busy(busy), .finish(finish), .launch(launch),
    .src_w(src_w), .dst(dst), .cnt(cnt), .arm(arm), .done(done),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  bce_retained_ram #(.WORDS(RAM_WORDS), .DW(32)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(imem_wdata)
  );

  bce_mover #(.RAM_AW(RAM_AW), .IMEM_AW(IMEM_AW)) u_mover (
    .clk(clk), .rst(rst), .launch(launch),
    .src_w(src_w), .dst(dst), .cnt(cnt),
    .busy(busy), .finish(finish),
    .ram_re(ram_re), .ram_raddr(ram_raddr),
    .imem_we(imem_we), .imem_addr(imem_addr)
  );

endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int RAM_AW  = 8,
  parameter int IMEM_AW = 12,
  localparam int CNT_W  = RAM_AW + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic               launch,
  input logic               imem_we,
  input logic [IMEM_AW-1:0] imem_addr,
  input logic [RAM_AW-1:0]  src_w,
  input logic [CNT_W-1:0]   cnt
);

  // R11
  we_in_copy_chk: assert property (@(posedge clk) disable iff (rst)
    imem_we |-> busy);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    imem_we && $past(imem_we) |-> imem_addr == IMEM_AW'($past(imem_addr) + 1'b1));

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !done);

  // R4
  finish_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(src_w) && $stable(cnt));

  // R9
  no_relaunch_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !launch);

endmodule

bind boot_copy_engine bce_checker #(.RAM_AW(RAM_AW), .IMEM_AW(IMEM_AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .launch(launch),
  .imem_we(imem_we), .imem_addr(imem_addr), .src_w(src_w), .cnt(cnt)
);

// File: tb/sim_boot_copy_engine.sv
`timescale 1ns/1ps
module sim_boot_copy_engine;

  localparam int IMEM_SZ = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwr_up_evt = 1'b0;
  logic        imem_we;
  logic [11:0] imem_addr;
  logic [31:0] imem_wdata;

  boot_copy_engine u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_up_evt(pwr_up_evt),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";

  // behavioural reference state
  typedef struct { int c; int a; logic [31:0] d; } wr_t;
  wr_t q[$];
  logic [31:0] m_mem [256];
  int m_src = 0, m_dst = 0, m_cnt = 0;
  bit m_arm = 0, m_started = 0;
  int m_start = 0, m_n = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit busy_after(int t);
    return m_started && m_n > 0 && t >= m_start && t <= m_start + m_n;
  endfunction

  function automatic bit done_after(int t);
    if (!m_started) return 1'b0;
    if (m_n == 0) return 1'b1;
    return t >= m_start + m_n + 1;
  endfunction

  task automatic trigger(int c);
    if (!busy_after(c - 1)) begin
      m_started = 1;
      m_start = c;
      m_n = m_cnt;
      for (int k = 0; k < m_cnt; k++) begin
        wr_t w;
        w.c = c + 1 + k;
        w.a = (m_dst + k) % IMEM_SZ;
        w.d = m_mem[(m_src + k) % 256];
        q.push_back(w);
      end
    end
  endtask

  task automatic bus_write(int addr, logic [31:0] data);
    int c;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 11'(addr); bus_wdata = data;
    @(posedge clk); #1;
    c = cyc;
    bus_we = 1'b0;
    if (addr >= 'h400) m_mem[(addr >> 2) & 255] = data;
    else if (addr == 'h00) begin
      if (data[31]) trigger(c);
      m_arm = data[30];
    end else if (!busy_after(c - 1)) begin
      if (addr == 'h04) m_src = (data >> 2) & 255;
      if (addr == 'h08) m_dst = data & (IMEM_SZ - 1);
      if (addr == 'h0C) m_cnt = data & 511;
    end
  endtask

  task automatic pulse_pwr();
    int c;
    @(negedge clk);
    pwr_up_evt = 1'b1;
    @(posedge clk); #1;
    c = cyc;
    pwr_up_evt = 1'b0;
    if (m_arm) trigger(c);
  endtask

  task automatic bus_read(int addr, string req, output logic [31:0] val);
    int c;
    logic [31:0] e;
    @(negedge clk);
    bus_addr = 11'(addr);
    @(posedge clk); #1;
    c = cyc;
    val = bus_rdata;
    case (addr)
      'h00: e = {busy_after(c - 1), m_arm, 30'b0};
      'h04: e = 32'(m_src) << 2;
      'h08: e = 32'(m_dst);
      'h0C: e = 32'(m_cnt);
      'h10: e = {31'b0, done_after(c - 1)};
      default: e = '0;
    endcase
    chk(val === e, req, $sformatf("read @%03h", addr), val, e);
  endtask

  task automatic wait_idle(string req);
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      bus_read('h00, req, v);
      if (!v[31]) break;
    end
    bus_read('h10, req, v);
  endtask

  // per-clock comparison of the target write port
  always @(negedge clk) begin
    if (!rst) begin
      bit e;
      if (q.size() > 0 && q[0].c < cyc) begin
        chk(1'b0, cur_req, "missing target write", 32'(q[0].c), 32'(cyc));
        void'(q.pop_front());
      end
      e = q.size() > 0 && q[0].c == cyc;
      if (e || imem_we) begin
        chk(imem_we === e, cur_req, "target strobe", 32'(imem_we), 32'(e));
        if (e && imem_we === 1'b1) begin
          chk(imem_addr === 12'(q[0].a), cur_req, "target addr", 32'(imem_addr), 32'(q[0].a));
          chk(imem_wdata === q[0].d, cur_req, "target data", imem_wdata, q[0].d);
        end
        if (e) void'(q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 100000);
    chk(1'b0, cur_req, "watchdog expired", 32'(cyc), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    cur_req = "R1";
    chk(imem_we === 1'b0, "R1", "strobe after reset", 32'(imem_we), 32'd0);
    bus_read('h00, "R1", v);
    bus_read('h04, "R1", v);
    bus_read('h08, "R1", v);
    bus_read('h0C, "R1", v);
    bus_read('h10, "R1", v);

    // R2 fill retained memory
    for (int i = 0; i < 256; i++)
      bus_write('h400 + 4 * i, 32'h5A00_0000 ^ (32'(i) * 32'h0001_0203));

    // R2 R3 R4 R5 basic host-started copy
    cur_req = "R2/R3";
    bus_write('h04, 32'h40);
    bus_write('h08, 32'h100);
    bus_write('h0C, 32'd8);
    bus_write('h00, 32'h8000_0000);
    wait_idle("R4");

    // R10 wrap of source and destination
    cur_req = "R10";
    bus_write('h04, 32'h3F8);
    bus_write('h08, 32'hFFE);
    bus_write('h0C, 32'd4);
    bus_write('h00, 32'h8000_0000);
    wait_idle("R10");

    // R7 zero count
    cur_req = "R7";
    bus_write('h0C, 32'd0);
    bus_write('h00, 32'h8000_0000);
    bus_read('h00, "R7", v);
    bus_read('h10, "R7", v);

    // R5 done cleared when a new copy starts
    cur_req = "R5";
    bus_write('h0C, 32'd5);
    bus_write('h00, 32'h8000_0000);
    bus_read('h10, "R5", v);
    wait_idle("R5");

    // R8 R9 reconfiguration and restart during a copy
    cur_req = "R9";
    bus_write('h04, 32'h10);
    bus_write('h08, 32'h200);
    bus_write('h0C, 32'd20);
    bus_write('h00, 32'h8000_0000);
    bus_write('h04, 32'h100);
    bus_write('h08, 32'h300);
    bus_write('h0C, 32'd3);
    bus_write('h00, 32'h8000_0000);
    wait_idle("R9");
    bus_read('h04, "R8", v);
    bus_read('h08, "R8", v);
    bus_read('h0C, "R8", v);

    // R6 power-up event without and with arm
    cur_req = "R6";
    pulse_pwr();
    for (int i = 0; i < 3; i++) bus_read('h00, "R6", v);
    bus_write('h0C, 32'd6);
    bus_write('h00, 32'h4000_0000);
    pulse_pwr();
    bus_read('h00, "R6", v);
    bus_read('h10, "R6", v);
    cur_req = "R9";
    pulse_pwr();
    wait_idle("R6");
    cur_req = "R6";
    bus_write('h400, 32'hCAFE_F00D);
    bus_write('h404, 32'h1234_5678);
    bus_write('h04, 32'h0);
    pulse_pwr();
    wait_idle("R6");

    repeat (4) @(posedge clk);
    #1;
    chk(q.size() == 0, "R11", "pending target writes", 32'(q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule